// File: doc/BRIEF.md
# Acquisition Packet Serialiser

This block turns one acquisition into a byte stream for a host link. A single-cycle `start` pulse captures the board identity, three 32-bit trigger tallies and a 24-bit board clock. The block then sends an opening header. Next come one frame per front-end chip that holds data, each carrying one fixed-size record per stored event. The packet ends with a closing marker and a 16-bit check word.

Event records come in from a readout capture stage on a valid/ready port. Each record carries the chip number, a 24-bit bunch-crossing stamp and a 128-bit hit pattern, which is 64 channels at two bits each. Two flags on the record tell the block when to close a chip's frame and when to close the whole packet. The output is a byte stream with valid/ready and an end-of-packet flag. Backpressure on that stream stalls the sequencer and the check-word update together.

Top module: `acq_frame_packer`

## Requirements
- R1: After `start`, the packet opens with 17 bytes in this order: 0xB0, board ID, board trigger tally, acquisition trigger tally, global trigger tally (each 4 bytes, most significant byte first), then the 24-bit board clock (3 bytes, most significant byte first).
- R2: Each chip frame opens with byte 0xB4 and closes with byte 0xA3.
- R3: Each event record is 20 bytes: the chip number, then the crossing stamp most significant byte first, then the hit pattern starting from bits 127:120 and ending with bits 7:0.
- R4: A record flagged as its chip's last event is followed by 0xA3. A frame whose closing record was flagged last-chip is followed by the closing marker 0xA0. Otherwise another 0xB4 frame follows.
- R5: When `acq_empty` is high at `start`, the packet is only the 17 header bytes, 0xA0 and the two check bytes, which is 20 bytes in all. No record is requested.
- R6: The last two bytes are the CRC-16 with polynomial 0x1021, initial value 0xFFFF, no reflection and no final inversion. It is computed over every byte from 0xB0 up to and including 0xA0, and the high byte is sent first.
- R7: `out_last` is high only on the low check byte. After that byte is accepted, `out_valid` drops.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold, and no byte is lost or repeated.
- R9: `rec_ready` is high only while a record is awaited. Each record is taken exactly once. A frame holds 1 to 128 records, and the 128th record of a frame must carry the last-event flag.
- R10: After reset, `out_valid`, `rec_ready` and `busy` are low. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet; header fields are captured on this cycle |
| acq_empty | input | 1 | Acquisition holds no chip data |
| board_id | input | 8 | Board identifier |
| cnt_board | input | 32 | Triggers seen while the board was ready |
| cnt_acq | input | 32 | Triggers seen while the host was ready |
| cnt_all | input | 32 | All triggers seen |
| board_time | input | 24 | Board crossing clock |
| rec_valid | input | 1 | Event record offered |
| rec_ready | output | 1 | Event record accepted |
| rec_chip | input | 8 | Chip number of the record |
| rec_bcid | input | 24 | Crossing stamp of the record |
| rec_hits | input | 128 | Hit pattern, 2 bits per channel |
| rec_last_evt | input | 1 | Last record of this chip |
| rec_last_chip | input | 1 | This chip is the last of the acquisition |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |
| busy | output | 1 | A packet is in progress |

## Verification
The packer is driven with an empty acquisition, a single chip holding one event, and a single chip holding the full 128 events. Randomised acquisitions of one to four chips with a few events each follow. The empty case isolates the shortcut from header straight to 0xA0. The single-event case checks the record byte order with no frame repetition. The full chip tests the frame length limit, and the multi-chip cases test how frames chain through the last-event and last-chip flags. A free-running sink and one that withholds `out_ready` at random are compared on identical byte and check-word expectations, so any byte dropped or repeated under stall shows up. A `start` pulse in the middle of a packet shows whether a running packet can be restarted.

// File: rtl/pkf_pkg.sv
package pkf_pkg;

   localparam logic [7:0] MK_OPEN      = 8'hB0;
   localparam logic [7:0] MK_FRAME_OPN = 8'hB4;
   localparam logic [7:0] MK_FRAME_CLS = 8'hA3;
   localparam logic [7:0] MK_CLOSE     = 8'hA0;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_FOPEN,
      ST_WAIT,
      ST_REC,
      ST_FCLOSE,
      ST_CLOSE,
      ST_CRC_HI,
      ST_CRC_LO
   } pkf_state_t;

endpackage

// File: rtl/pkf_crc.sv
module pkf_crc #(
   parameter int          CRC_W = 16,
   parameter logic [15:0] POLY  = 16'h1021,
   parameter logic [15:0] SEED  = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             en,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc
);

   if (CRC_W < 8 || CRC_W > 16) begin : g_bad_width
      $error("pkf_crc: CRC_W must lie in 8..16");
   end

   logic [CRC_W-1:0] chain [0:8];
   logic [CRC_W-1:0] crc_q;

   if (CRC_W == 8) begin : g_w8
      assign chain[0] = crc_q ^ din;
   end else begin : g_wide
      assign chain[0] = crc_q ^ {din, {(CRC_W-8){1'b0}}};
   end

   for (genvar b = 0; b < 8; b++) begin : g_bit
      assign chain[b+1] = chain[b][CRC_W-1]
                          ? ({chain[b][CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0])
                          :  {chain[b][CRC_W-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init) crc_q <= SEED[CRC_W-1:0];
      else if (en)        crc_q <= chain[8];
   end

   assign crc = crc_q;

   AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !init) |=> $stable(crc_q)); // R8

endmodule

// File: rtl/pkf_byte_sel.sv
module pkf_byte_sel #(
   parameter int NBYTES = 17,
   parameter int IDX_W  = 5
) (
   input  logic [NBYTES*8-1:0] word,
   input  logic [IDX_W-1:0]    idx,
   output logic [7:0]          byte_o
);

   if (NBYTES > (1 << IDX_W)) begin : g_bad_idx
      $error("pkf_byte_sel: IDX_W too small for NBYTES");
   end

   logic [7:0] lane [0:NBYTES-1];

   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign lane[k] = word[(NBYTES-k)*8-1 -: 8];
   end

   always_comb begin
      byte_o = 8'h00;
      for (int k = 0; k < NBYTES; k++)
         if (idx == IDX_W'(k)) byte_o = lane[k];
   end

endmodule

// File: rtl/acq_frame_packer.sv
module acq_frame_packer
   import pkf_pkg::*;
#(
   parameter int ID_W    = 8,
   parameter int CNT_W   = 32,
   parameter int TIME_W  = 24,
   parameter int CHIP_W  = 8,
   parameter int BCID_W  = 24,
   parameter int HIT_W   = 128,
   parameter int MAX_EVT = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              acq_empty,
   input  logic [ID_W-1:0]   board_id,
   input  logic [CNT_W-1:0]  cnt_board,
   input  logic [CNT_W-1:0]  cnt_acq,
   input  logic [CNT_W-1:0]  cnt_all,
   input  logic [TIME_W-1:0] board_time,
   input  logic              rec_valid,
   output logic              rec_ready,
   input  logic [CHIP_W-1:0] rec_chip,
   input  logic [BCID_W-1:0] rec_bcid,
   input  logic [HIT_W-1:0]  rec_hits,
   input  logic              rec_last_evt,
   input  logic              rec_last_chip,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic              busy
);

   localparam int HDR_BITS  = 8 + ID_W + 3*CNT_W + TIME_W;
   localparam int REC_BITS  = CHIP_W + BCID_W + HIT_W;
   localparam int HDR_BYTES = HDR_BITS / 8;
   localparam int REC_BYTES = REC_BITS / 8;
   localparam int MAX_BYTES = (HDR_BYTES > REC_BYTES) ? HDR_BYTES : REC_BYTES;
   localparam int IDX_W     = $clog2(MAX_BYTES);
   localparam int EVT_W     = $clog2(MAX_EVT + 1);

   if ((ID_W % 8) != 0 || (CNT_W % 8) != 0 || (TIME_W % 8) != 0 ||
       (CHIP_W % 8) != 0 || (BCID_W % 8) != 0 || (HIT_W % 8) != 0) begin : g_bad_align
      $error("acq_frame_packer: every field width must be a whole number of bytes");
   end
   if (MAX_EVT < 1) begin : g_bad_depth
      $error("acq_frame_packer: MAX_EVT must be at least 1");
   end

   pkf_state_t           state_q;
   logic [IDX_W-1:0]     idx_q;
   logic [HDR_BITS-1:0]  hdr_q;
   logic [REC_BITS-1:0]  rec_q;
   logic                 last_evt_q, last_chip_q, empty_q;
   logic [EVT_W-1:0]     evt_q;
   logic [7:0]           hdr_byte, rec_byte;
   logic [15:0]          crc;
   logic                 adv, rec_take, crc_en, crc_init;

   pkf_byte_sel #(.NBYTES(HDR_BYTES), .IDX_W(IDX_W)) u_hdr_sel (
      .word(hdr_q), .idx(idx_q), .byte_o(hdr_byte));

   pkf_byte_sel #(.NBYTES(REC_BYTES), .IDX_W(IDX_W)) u_rec_sel (
      .word(rec_q), .idx(idx_q), .byte_o(rec_byte));

   pkf_crc #(.CRC_W(16), .POLY(16'h1021), .SEED(16'hFFFF)) u_crc (
      .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
      .din(out_data), .crc(crc));

   always_comb begin
      out_valid = 1'b1;
      out_data  = 8'h00;
      out_last  = 1'b0;
      unique case (state_q)
         ST_HDR:    out_data = hdr_byte;
         ST_FOPEN:  out_data = MK_FRAME_OPN;
         ST_REC:    out_data = rec_byte;
         ST_FCLOSE: out_data = MK_FRAME_CLS;
         ST_CLOSE:  out_data = MK_CLOSE;
         ST_CRC_HI: out_data = crc[15:8];
         ST_CRC_LO: begin out_data = crc[7:0]; out_last = 1'b1; end
         default:   out_valid = 1'b0;
      endcase
   end

   assign rec_ready = (state_q == ST_WAIT);
   assign busy      = (state_q != ST_IDLE);
   assign adv       = out_valid && out_ready;
   assign rec_take  = rec_valid && rec_ready;
   assign crc_init  = (state_q == ST_IDLE) && start;
   assign crc_en    = adv && (state_q != ST_CRC_HI) && (state_q != ST_CRC_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         idx_q       <= '0;
         hdr_q       <= '0;
         rec_q       <= '0;
         last_evt_q  <= 1'b0;
         last_chip_q <= 1'b0;
         empty_q     <= 1'b0;
         evt_q       <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               hdr_q   <= {MK_OPEN, board_id, cnt_board, cnt_acq, cnt_all, board_time};
               empty_q <= acq_empty;
               idx_q   <= '0;
               state_q <= ST_HDR;
            end
            ST_HDR: if (adv) begin
               if (idx_q == IDX_W'(HDR_BYTES-1)) begin
                  idx_q   <= '0;
                  state_q <= empty_q ? ST_CLOSE : ST_FOPEN;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_FOPEN: if (adv) begin
               evt_q   <= '0;
               state_q <= ST_WAIT;
            end
            ST_WAIT: if (rec_take) begin
               rec_q       <= {rec_chip, rec_bcid, rec_hits};
               last_evt_q  <= rec_last_evt;
               last_chip_q <= rec_last_chip;
               evt_q       <= evt_q + 1'b1;
               idx_q       <= '0;
               state_q     <= ST_REC;
            end
            ST_REC: if (adv) begin
               if (idx_q == IDX_W'(REC_BYTES-1)) begin
                  idx_q   <= '0;
                  state_q <= last_evt_q ? ST_FCLOSE : ST_WAIT;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_FCLOSE: if (adv) state_q <= last_chip_q ? ST_CLOSE : ST_FOPEN;
            ST_CLOSE:  if (adv) state_q <= ST_CRC_HI;
            ST_CRC_HI: if (adv) state_q <= ST_CRC_LO;
            ST_CRC_LO: if (adv) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

   AST_OPEN_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (out_valid && out_data == MK_OPEN)); // R1

   AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_last && out_ready) |=> !out_valid); // R7

   AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_take && evt_q == EVT_W'(MAX_EVT-1)) |-> rec_last_evt); // R9

   AST_NO_OUT_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      rec_ready |=> (out_valid || rec_ready)); // R9

endmodule

// File: tb/acq_frame_packer_test.sv
module acq_frame_packer_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, acq_empty = 1'b0;
   logic [7:0]   board_id = '0;
   logic [31:0]  cnt_board = '0, cnt_acq = '0, cnt_all = '0;
   logic [23:0]  board_time = '0;
   logic         rec_valid = 1'b0, rec_last_evt = 1'b0, rec_last_chip = 1'b0;
   logic [7:0]   rec_chip = '0;
   logic [23:0]  rec_bcid = '0;
   logic [127:0] rec_hits = '0;
   logic         out_ready = 1'b0;
   logic         rec_ready, out_valid, out_last, busy;
   logic [7:0]   out_data;

   int checks = 0, failures = 0, cycles = 0;
   logic [7:0] exp_q[$], got_q[$];
   int         mark_q[$];
   int         last_cnt, last_pos, stall_err, taken;

   always #4 clk = ~clk;

   acq_frame_packer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .acq_empty(acq_empty),
      .board_id(board_id), .cnt_board(cnt_board), .cnt_acq(cnt_acq),
      .cnt_all(cnt_all), .board_time(board_time),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_chip(rec_chip),
      .rec_bcid(rec_bcid), .rec_hits(rec_hits), .rec_last_evt(rec_last_evt),
      .rec_last_chip(rec_last_chip), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .busy(busy));

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run hung, got %0d expected completion", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push32(input logic [31:0] v);
      for (int i = 3; i >= 0; i--) exp_q.push_back(v[i*8 +: 8]);
   endtask

   task automatic cmp_range(input int lo, input int hi, input string tag);
      int bad = -1;
      for (int i = lo; i <= hi; i++)
         if (bad < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) bad = i;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, tag, (bad < got_q.size()) ? got_q[bad] : -1, exp_q[bad]);
   endtask

   // nchips==0 means empty acquisition; ev[c] events for chip c
   task automatic run_acq(input int nchips, input int ev[4], input int ready_pct,
                          input bit poke_start);
      logic [7:0]   chip_a[$];
      logic [23:0]  bcid_a[$];
      logic [127:0] hit_a[$];
      bit           le_a[$], lc_a[$];
      logic [15:0]  crc;
      int           total;
      exp_q.delete(); got_q.delete(); mark_q.delete();
      board_id   = 8'($urandom);
      cnt_board  = $urandom; cnt_acq = $urandom; cnt_all = $urandom;
      board_time = 24'($urandom);
      exp_q.push_back(8'hB0); exp_q.push_back(board_id);
      push32(cnt_board); push32(cnt_acq); push32(cnt_all);
      for (int i = 2; i >= 0; i--) exp_q.push_back(board_time[i*8 +: 8]);
      for (int c = 0; c < nchips; c++) begin
         mark_q.push_back(exp_q.size()); exp_q.push_back(8'hB4);
         for (int e = 0; e < ev[c]; e++) begin
            chip_a.push_back(8'(c + 3));
            bcid_a.push_back(24'($urandom));
            hit_a.push_back({$urandom, $urandom, $urandom, $urandom});
            le_a.push_back(e == ev[c]-1);
            lc_a.push_back(c == nchips-1);
            exp_q.push_back(chip_a[$]);
            for (int i = 2; i >= 0; i--) exp_q.push_back(bcid_a[$][i*8 +: 8]);
            for (int i = 15; i >= 0; i--) exp_q.push_back(hit_a[$][i*8 +: 8]);
         end
         mark_q.push_back(exp_q.size()); exp_q.push_back(8'hA3);
      end
      exp_q.push_back(8'hA0);
      crc = 16'hFFFF;
      foreach (exp_q[i]) crc = crc_upd(crc, exp_q[i]);
      exp_q.push_back(crc[15:8]); exp_q.push_back(crc[7:0]);
      total = chip_a.size();
      last_cnt = 0; last_pos = -1; stall_err = 0; taken = 0;

      @(negedge clk);
      acq_empty = (nchips == 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      fork
         begin : feeder
            for (int r = 0; r < total; r++) begin
               rec_valid = 1'b1; rec_chip = chip_a[r]; rec_bcid = bcid_a[r];
               rec_hits = hit_a[r]; rec_last_evt = le_a[r]; rec_last_chip = lc_a[r];
               while (!rec_ready) @(negedge clk);
               @(negedge clk);
               taken++;
               rec_valid = 1'b0;
            end
         end
         begin : sink
            bit         stalled = 1'b0;
            logic [7:0] held = '0;
            int         n = 0;
            while (last_cnt == 0) begin
               if (stalled && !(out_valid && out_data === held)) stall_err++;
               out_ready = ($urandom_range(99) < ready_pct);
               stalled = out_valid && !out_ready;
               held = out_data;
               if (out_valid && out_ready) begin
                  got_q.push_back(out_data);
                  if (out_last) begin last_cnt++; last_pos = n; end
                  n++;
               end
               @(negedge clk);
            end
            out_ready = 1'b0;
         end
         begin : poker
            if (poke_start) begin
               repeat (30) @(negedge clk);
               board_id = ~board_id; start = 1'b1;
               @(negedge clk);
               start = 1'b0;
            end
         end
      join
      // R1 header, R2 markers, R3 records, R4 closing marker, R6 check word
      cmp_range(0, 16, "R1 header bytes");
      begin
         int bad = -1;
         foreach (mark_q[i])
            if (bad < 0 && (mark_q[i] >= got_q.size() || got_q[mark_q[i]] !== exp_q[mark_q[i]]))
               bad = mark_q[i];
         check(bad < 0, "R2 frame markers", (bad >= 0 && bad < got_q.size()) ? got_q[bad] : 0,
               (bad >= 0) ? exp_q[bad] : 0);
      end
      cmp_range(17, exp_q.size()-4, "R3 record bytes");
      cmp_range(exp_q.size()-3, exp_q.size()-3, "R4 closing marker");
      cmp_range(exp_q.size()-2, exp_q.size()-1, "R6 check word");
      check(got_q.size() == exp_q.size(), "R8 packet length", got_q.size(), exp_q.size());
      check(last_pos == exp_q.size()-1 && last_cnt == 1, "R7 last flag position",
            last_pos, exp_q.size()-1);
      check(stall_err == 0, "R8 hold under stall", stall_err, 0);
      check(taken == total, "R9 records taken", taken, total);
      @(negedge clk);
      check(!out_valid && !busy, "R7 idle after packet", {out_valid, busy}, 0);
      if (poke_start) check(!busy && !out_valid, "R10 start ignored while busy", busy, 0);
   endtask

   initial begin
      int ev[4];
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      check(!out_valid && !rec_ready && !busy, "R10 reset state",
            {out_valid, rec_ready, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      ev = '{0, 0, 0, 0};
      run_acq(0, ev, 100, 1'b0);
      check(got_q.size() == 20, "R5 empty packet length", got_q.size(), 20);
      check(taken == 0, "R5 no record requested", taken, 0);

      ev = '{1, 0, 0, 0};
      run_acq(1, ev, 100, 1'b0);

      ev = '{128, 0, 0, 0};
      run_acq(1, ev, 70, 1'b0);   // R9 full frame

      for (int t = 0; t < 8; t++) begin
         int nc = $urandom_range(4, 1);
         for (int c = 0; c < 4; c++) ev[c] = $urandom_range(6, 1);
         run_acq(nc, ev, (t % 2) ? 100 : 50, t == 3);
      end

      ev = '{2, 1, 0, 0};
      run_acq(2, ev, 20, 1'b1);   // R10 restart attempt under heavy stall

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule